// File: doc/BRIEF.md
# SRAM bus cycle wait controller

This block runs single read or write cycles on an external asynchronous-SRAM-style bus. A host starts a transfer with a one-clock start strobe that carries the address, the direction, the write data and a flag that asks for a DMA acknowledge. The controller then walks the bus through a fixed set of phases:

- a setup phase (T1);
- a programmable run of software wait phases (Tw);
- zero or more ready-extension phases (Twe);
- a closing phase (T2).

It drives the address, an active-low chip select, an active-low write direction, active-low read and write strobes, an active-low bus-start pulse and an active-low DMA acknowledge.

When software waits are in use, the active-low ready input from the device can stretch the cycle further. Ready is looked at only on the clock edge that ends the last software wait phase, and then on each edge that ends an extension phase. A high ready level that arrives earlier in the cycle has no effect. When the transfer completes, the block raises a one-clock done pulse, and for reads it presents the captured read data at the same time. It accepts the next start strobe in that same clock.

Top module: `sram_wait_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, mem_cs_n, mem_bs_n, mem_rd_n, mem_we_n, mem_rw_n and mem_dack_n are 1, mem_wdata_oe and rsp_done are 0, and req_ready is 1.
- R2: A req_start seen at a rising edge while req_ready is 1 latches req_addr, req_write (1 = write), req_wdata, req_dma and cfg_sw_waits. T1 starts in the next clock. A req_start seen while req_ready is 0 is ignored and does not alter the running cycle.
- R3: mem_bs_n is 0 in T1 only, so it is low for exactly one clock per transfer.
- R4: From T1 through T2, mem_cs_n is 0, mem_addr equals the latched address, and mem_rw_n is 0 for a write and 1 for a read. mem_dack_n is 0 over the same span when req_dma was 1 at acceptance.
- R5: For a read, mem_rd_n is 0 from T1 through T2 and mem_we_n stays 1. mem_rdata is captured on the edge that ends T2 and shows on rsp_rdata while rsp_done is 1.
- R6: For a write, mem_we_n is 0, mem_wdata_oe is 1 and mem_wdata equals the latched data from T1 through T2, including every wait phase. mem_rd_n stays 1.
- R7: With a latched wait count W greater than 0, exactly W Tw clocks follow T1. With W equal to 0, T2 follows T1 directly, mem_rdy_n is not looked at, and the transfer lasts 2 clocks.
- R8: mem_rdy_n is sampled first on the edge that ends the last Tw. Its level during T1 or during any earlier Tw does not lengthen the cycle.
- R9: Each sampled mem_rdy_n of 1 adds one Twe clock, and the next edge samples it again. A sampled 0 moves the bus to T2. The total transfer is W + E + 2 clocks with mem_cs_n low, where E is the number of sampled 1 values.
- R10: rsp_done is 1 for exactly one clock, the clock after T2. req_ready is 1 in that clock, and a req_start given in it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-clock transfer start strobe |
| req_write | input | 1 | Direction, 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_dma | input | 1 | Assert the DMA acknowledge for this transfer |
| cfg_sw_waits | input | WAIT_W | Number of software wait phases |
| req_ready | output | 1 | High when a start strobe will be accepted |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Bus address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rw_n | output | 1 | Direction line, 0 = write |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 1 | Bus-start pulse, active low |
| mem_dack_n | output | 1 | DMA acknowledge, active low |
| mem_wdata | output | DATA_W | Write data driven to the bus |
| mem_wdata_oe | output | 1 | Write data output enable |
| mem_rdata | input | DATA_W | Read data from the bus |
| mem_rdy_n | input | 1 | Device ready, active low |

## Verification
The bench holds ready high during T1 and the first Tw of a three-wait transfer. A controller that sampled early would stretch that cycle, and the per-clock model would catch the extra Twe clock. It also holds ready high across several extension edges, so that a design that counts Twe clocks wrongly, or that looks at ready only once, is caught by the cycle-length check. Transfers with zero waits keep ready high throughout to show that it is ignored there. Further cases cover a start strobe inside a running cycle, a start given in the done clock, and the largest wait count, so that a design that accepts too early or loses the back-to-back request shows a wrong address or a missing bus-start pulse.

// File: rtl/sram_wait_pkg.sv
package sram_wait_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_TW   = 3'd2,
    PH_TWE  = 3'd3,
    PH_T2   = 3'd4
  } bus_phase_e;

  // The bus is owned from T1 through T2.
  function automatic logic phase_active(input bus_phase_e p);
    return (p != PH_IDLE);
  endfunction

  // Ready is looked at on the edge closing the last Tw or any Twe.
  function automatic logic rdy_sample_point(input bus_phase_e p, input logic cnt_zero);
    return ((p == PH_TW) && cnt_zero) || (p == PH_TWE);
  endfunction

  // Clocks with chip select low for a transfer.
  function automatic int cycle_len(input int sw_waits, input int ext_waits);
    return (sw_waits == 0) ? 2 : (sw_waits + ext_waits + 2);
  endfunction

endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_dma,
  input  logic [WAIT_W-1:0] cfg_sw_waits,
  output logic              q_write,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic              q_dma,
  output logic [WAIT_W-1:0] q_waits
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_dma   <= 1'b0;
      q_waits <= '0;
    end else if (accept) begin
      q_write <= req_write;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
      q_dma   <= req_dma;
      q_waits <= cfg_sw_waits;
    end
  end

  // Request fields only change on an accepted start.
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(q_addr) && $stable(q_write) && $stable(q_waits))) else $error("latch moved"); // R2

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_wait_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [WAIT_W-1:0] q_waits,
  input  logic              mem_rdy_n,
  output bus_phase_e        phase,
  output logic              accept,
  output logic              ev_sample,
  output logic              ev_extend,
  output logic              ev_finish
);

  localparam logic [WAIT_W-1:0] CNT_ONE = WAIT_W'(1);

  bus_phase_e        phase_q, phase_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign accept    = (phase_q == PH_IDLE) && req_start;
  assign ev_sample = rdy_sample_point(phase_q, cnt_zero);
  assign ev_extend = ev_sample && mem_rdy_n;
  assign ev_finish = (phase_q == PH_T2);
  assign phase     = phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_T1;
      PH_T1: begin
        if (q_waits == '0) begin
          phase_d = PH_T2;
        end else begin
          phase_d = PH_TW;
          cnt_d   = q_waits - CNT_ONE;
        end
      end
      PH_TW: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_ONE;
        end else begin
          phase_d = mem_rdy_n ? PH_TWE : PH_T2;
        end
      end
      PH_TWE: phase_d = mem_rdy_n ? PH_TWE : PH_T2;
      PH_T2:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_T1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T1) |=> (phase_q != PH_T1)) else $error("T1 repeated"); // R3
  AST_ZERO_WAIT_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T1 && q_waits == '0) |=> (phase_q == PH_T2)) else $error("zero wait path"); // R7
  AST_EARLY_RDY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T1 && q_waits != '0) |=> (phase_q == PH_TW)) else $error("T1 not to Tw"); // R8
  AST_NOTREADY_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_extend |=> (phase_q == PH_TWE)) else $error("no extension"); // R9
  AST_READY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sample && !mem_rdy_n) |=> (phase_q == PH_T2)) else $error("no T2 after ready"); // R9
  AST_T2_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (phase_q == PH_IDLE)) else $error("T2 not closing"); // R10

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_wait_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_phase_e        phase,
  input  logic              q_write,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [DATA_W-1:0] q_wdata,
  input  logic              q_dma,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rw_n,
  output logic              mem_rd_n,
  output logic              mem_we_n,
  output logic              mem_bs_n,
  output logic              mem_dack_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);

  logic on_bus, rd_cyc, wr_cyc, capture;

  assign on_bus  = phase_active(phase);
  assign rd_cyc  = on_bus && !q_write;
  assign wr_cyc  = on_bus && q_write;
  assign capture = (phase == PH_T2) && !q_write;

  assign mem_addr     = q_addr;
  assign mem_cs_n     = !on_bus;
  assign mem_rw_n     = !wr_cyc;
  assign mem_rd_n     = !rd_cyc;
  assign mem_we_n     = !wr_cyc;
  assign mem_bs_n     = (phase != PH_T1);
  assign mem_dack_n   = !(on_bus && q_dma);
  assign mem_wdata    = wr_cyc ? q_wdata : '0;
  assign mem_wdata_oe = wr_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= (phase == PH_T2);
      if (capture) rsp_rdata <= mem_rdata;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done) else $error("done too long"); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!mem_rd_n, !mem_we_n})) else $error("both strobes"); // R5

endmodule

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl
  import sram_wait_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_dma,
  input  logic [WAIT_W-1:0] cfg_sw_waits,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rw_n,
  output logic              mem_rd_n,
  output logic              mem_we_n,
  output logic              mem_bs_n,
  output logic              mem_dack_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy_n
);

  bus_phase_e        phase;
  logic              accept, ev_sample, ev_extend, ev_finish;
  logic              q_write, q_dma;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [WAIT_W-1:0] q_waits;

  assign req_ready = (phase == PH_IDLE);

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_dma(req_dma), .cfg_sw_waits(cfg_sw_waits),
    .q_write(q_write), .q_addr(q_addr), .q_wdata(q_wdata),
    .q_dma(q_dma), .q_waits(q_waits)
  );

  sram_phase_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .q_waits(q_waits),
    .mem_rdy_n(mem_rdy_n), .phase(phase), .accept(accept),
    .ev_sample(ev_sample), .ev_extend(ev_extend), .ev_finish(ev_finish)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .q_write(q_write), .q_addr(q_addr), .q_wdata(q_wdata), .q_dma(q_dma),
    .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rw_n(mem_rw_n),
    .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n),
    .mem_dack_n(mem_dack_n), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)) else $error("address moved"); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && req_start) |=> !(phase == PH_T1)) else $error("start taken while busy"); // R2
  AST_BS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_bs_n |=> mem_bs_n) else $error("bus start too long"); // R3
  AST_FINISH_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (rsp_done && req_ready)) else $error("done missing"); // R10

endmodule

// File: tb/sram_wait_ctrl_tb.sv
`timescale 1ns/1ps
module sram_wait_ctrl_tb_top;

  localparam int AW = 26;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0, req_write = 1'b0, req_dma = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [WW-1:0] cfg_sw_waits = '0;
  logic          req_ready, rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_rw_n, mem_rd_n, mem_we_n, mem_bs_n, mem_dack_n, mem_wdata_oe;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rdy_n = 1'b1;

  always #2.5 clk = ~clk;

  sram_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_dma(req_dma),
    .cfg_sw_waits(cfg_sw_waits), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_rw_n(mem_rw_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
    .mem_bs_n(mem_bs_n), .mem_dack_n(mem_dack_n), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_rdy_n(mem_rdy_n)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  function automatic logic [DW-1:0] rd_pattern(input logic [AW-1:0] a);
    return (DW'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // Pending stimulus, taken into the model on acceptance
  logic [63:0] pend_sched = '0;
  int          pend_len = 0;
  string       pend_tag = "R2";

  // Behavioural reference model
  bit          m_busy = 0, m_res = 0, m_wr = 0, m_dma = 0, m_done = 0;
  int          m_k = 0, m_w = 0, m_ext = 0, m_len = 0, m_cs_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0, m_rdata = '0;
  logic [63:0] m_sched = '0;
  string       m_tag = "R2";

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_k = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_res && m_k == m_w + m_ext + 1) begin
          m_busy = 0; m_done = 1;
          if (!m_wr) m_rdata = mem_rdata;
        end else if (!m_res && m_k == m_w + m_ext) begin
          if (mem_rdy_n) m_ext++;
          else m_res = 1;
        end
        m_k++;
      end else if (req_start) begin
        m_busy = 1; m_k = 0; m_ext = 0;
        m_w = int'(cfg_sw_waits); m_res = (cfg_sw_waits == '0);
        m_wr = req_write; m_dma = req_dma; m_addr = req_addr; m_wdata = req_wdata;
        m_sched = pend_sched; m_len = pend_len; m_tag = pend_tag;
      end
    end
  end

  // Per-clock comparison, then bus-side stimulus for the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4", "cs_n", 64'(mem_cs_n), 64'(!m_busy));
      chk("R3", "bs_n", 64'(mem_bs_n), 64'(!(m_busy && m_k == 0)));
      chk("R5", "rd_n", 64'(mem_rd_n), 64'(!(m_busy && !m_wr)));
      chk("R6", "we_n", 64'(mem_we_n), 64'(!(m_busy && m_wr)));
      chk("R4", "rw_n", 64'(mem_rw_n), 64'(!(m_busy && m_wr)));
      chk("R4", "dack_n", 64'(mem_dack_n), 64'(!(m_busy && m_dma)));
      chk("R10", "ready", 64'(req_ready), 64'(!m_busy));
      chk("R10", "done", 64'(rsp_done), 64'(m_done));
      if (m_busy) chk("R4", "addr", 64'(mem_addr), 64'(m_addr));
      if (m_busy && m_wr) begin
        chk("R6", "wdata", 64'(mem_wdata), 64'(m_wdata));
        chk("R6", "wdata_oe", 64'(mem_wdata_oe), 64'd1);
      end
      if (m_busy && m_k == 0) chk("R2", "T1 after accept", 64'(mem_bs_n), 64'd0);
      if (m_done && !m_wr) chk("R5", "rdata", 64'(rsp_rdata), 64'(m_rdata));
      if (!mem_cs_n) m_cs_cnt++;
      if (rsp_done) begin
        chk(m_tag, "cycle length", 64'(m_cs_cnt), 64'(m_len));
        m_cs_cnt = 0;
      end
      mem_rdy_n <= m_busy ? m_sched[m_k[5:0]] : 1'b1;
      mem_rdata <= m_busy ? rd_pattern(m_addr) : '0;
    end
  end

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int w, input bit dma, input logic [63:0] s,
                      input string tag, input bit imm, input bit poke);
    int e;
    e = 0;
    if (w > 0) begin
      for (int i = w; i < 64 && s[i]; i++) e++;
    end
    if (!imm) @(negedge clk);
    pend_sched = s;
    pend_len = (w == 0) ? 2 : w + e + 2;
    pend_tag = tag;
    req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_dma = dma; cfg_sw_waits = WW'(w);
    @(negedge clk);
    req_start = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_start = 1'b1; req_addr = ~a; req_write = ~wr; cfg_sw_waits = '0;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (!rsp_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset cs_n", 64'(mem_cs_n), 64'd1);
    chk("R1", "reset bs_n", 64'(mem_bs_n), 64'd1);
    chk("R1", "reset strobes", 64'({mem_rd_n, mem_we_n, mem_rw_n, mem_dack_n}), 64'hF);
    chk("R1", "reset oe/done", 64'({mem_wdata_oe, rsp_done}), 64'd0);
    chk("R1", "reset ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", 64'({mem_cs_n, req_ready, rsp_done}), 64'b110);

    // Zero waits: ready held high throughout is ignored
    xfer(0, 26'h000_1234, '0, 0, 0, {64{1'b1}}, "R7", 0, 0);
    // One wait, ready low at the sample edge
    xfer(1, 26'h015_5AA0, 32'hDEAD_BEEF, 1, 0, 64'd0, "R7", 0, 0);
    // Ready high in T1 and first Tw only: no extension
    xfer(0, 26'h2AB_CDEF, '0, 3, 0, 64'b0011, "R8", 0, 0);
    // Three sampled not-ready edges from the last Tw
    xfer(1, 26'h3FF_0001, 32'h1357_9BDF, 2, 1, 64'b11100, "R9", 0, 0);
    // One extension with DMA acknowledge on a read
    xfer(0, 26'h001_0F0F, '0, 1, 1, 64'b10, "R9", 0, 0);
    // Start strobe in the middle of a running cycle is ignored
    xfer(0, 26'h123_4567, '0, 4, 0, 64'd0, "R2", 0, 1);
    // Back-to-back: start given in the done clock
    xfer(1, 26'h0AA_AAAA, 32'hCAFE_F00D, 0, 0, 64'd0, "R10", 0, 0);
    xfer(0, 26'h155_5555, '0, 2, 1, 64'b100, "R10", 1, 0);
    // Largest wait count, then a long extension
    xfer(1, 26'h3C3_C3C3, 32'h0F0F_F0F0, 15, 0, 64'd0, "R7", 0, 0);
    xfer(0, 26'h0C3_3C00, '0, 15, 0, 64'h003F_8000, "R9", 0, 0);
    repeat (3) @(negedge clk);
    chk("R10", "idle at end", 64'({mem_cs_n, req_ready}), 64'b11);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule